// File: doc/BRIEF.md
# Looping Playback Voice Address Generator

This block drives the fetch side of a single playback voice in a multi-voice audio engine. Software loads a buffer base address, an end offset, a pitch step and a sample format through a small register write port, then issues a start. From then on, every engine tick (a strobe at the 48 kHz engine rate) adds the step to a fixed-point play position that has a 12-bit fraction. Each time the integer sample offset moves, the block emits a byte address for the memory fetcher, along with a one-cycle request strobe.

The step is a 4.12 ratio of the voice rate to the engine rate, so 0x1000 plays one sample per tick. When the position passes the end offset, the voice either loops back to offset zero and keeps its leftover fraction, or halts at the end offset. A half-buffer flag shows which half of the buffer is playing, and a pulse marks each change of that flag so the host can refill the half that was just released. The offset width is 16 bits by default. Setting `WIDE_OFS` selects 24-bit offsets.

Top module: `voice_addr_gen`

## Requirements
- R1: After reset the voice is stopped, with current offset 0, half flag 0, no request and no half pulse. Base, end, step and format all read as zero (so the address is 0).
- R2: A write with `wr_sel` 0 loads the base from `wr_data[29:0]`, and bits 31:30 are dropped. Select 1 loads the current offset and select 2 the end offset, each from the low offset-width bits. Select 3 loads the step from `wr_data[15:0]` and select 4 the format from `wr_data[3:0]`. A current-offset write made while stopped also clears the fraction.
- R3: `start` clears the offset, the fraction and the half flag, and sets `running`. `stop` clears `running` and wins over `start` in the same cycle.
- R4: On each `tick` while running, the step is added to the position {offset, 12-bit fraction}. A step of 0x1000 advances exactly one sample per tick.
- R5: When format bit 0 (loop) is 1 and the new integer offset would exceed the end offset, the offset becomes 0 and the new 12-bit fraction is kept.
- R6: When format bit 0 is 0 and the new integer offset would exceed the end offset, the offset is set to the end offset and `running` drops.
- R7: After every processed tick, the half flag equals (new offset >= (end+1)/2), and it is forced to 0 on a wrap. `half_irq` is high for exactly the cycle in which the flag shows a changed value, including a clear caused by start.
- R8: `req` is high for one cycle after a processed tick that changed the integer offset, or that wrapped.
- R9: `addr` = (base + offset × frame bytes) mod 2^30. Frame bytes are 1 << (format bit 3 + format bit 2), where bit 3 selects 16-bit samples and bit 2 selects stereo. Bit 1 (signed) has no effect on addressing.
- R10: A current-offset write while running is ignored.
- R11: `tick` has no effect while the voice is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 base, 1 offset, 2 end, 3 step, 4 format) |
| wr_data | input | 32 | Register write data |
| start | input | 1 | Start the voice from offset 0 |
| stop | input | 1 | Halt the voice |
| tick | input | 1 | Engine-rate advance strobe |
| running | output | 1 | Voice is playing |
| cur_ofs | output | OFS_W | Current integer sample offset |
| half | output | 1 | Buffer-half flag |
| half_irq | output | 1 | One-cycle pulse on each half-flag change |
| req | output | 1 | Sample fetch request strobe |
| addr | output | 30 | Byte address of the current sample frame |

## Verification
The bench targets the wrap boundary, where the new integer position lands exactly one past the end offset. A comparison off by one would replay the end sample or skip offset zero. Steps above 0x1000 carry several samples per tick. A design that drops the fraction on a wrap would drift out of phase with the bench model within a few loops. Non-looping halts, current-offset writes during play, and base writes with the top two bits set are all aimed at. A design getting these wrong would run past the end offset, jump mid-buffer, or place fetches above the 1 GB window. The bench also checks the half pulse on a restart: a design that only pulses on tick-driven changes would miss the clear caused by start.

// File: rtl/vag_pkg.sv
package vag_pkg;
   localparam int unsigned SEL_W     = 3;
   localparam logic [2:0]  SEL_BASE  = 3'd0;
   localparam logic [2:0]  SEL_CUR   = 3'd1;
   localparam logic [2:0]  SEL_END   = 3'd2;
   localparam logic [2:0]  SEL_STEP  = 3'd3;
   localparam logic [2:0]  SEL_FMT   = 3'd4;

   localparam int unsigned FMT_W     = 4;
   localparam int unsigned FMT_LOOP  = 0;
   localparam int unsigned FMT_SGN   = 1;
   localparam int unsigned FMT_STEREO = 2;
   localparam int unsigned FMT_WIDE  = 3;

   typedef struct packed {
      logic loop_en;
      logic is_signed;
      logic stereo;
      logic wide16;
   } fmt_t;

   function automatic fmt_t fmt_unpack(input logic [FMT_W-1:0] raw);
      fmt_t f;
      f.loop_en   = raw[FMT_LOOP];
      f.is_signed = raw[FMT_SGN];
      f.stereo    = raw[FMT_STEREO];
      f.wide16    = raw[FMT_WIDE];
      return f;
   endfunction

   function automatic logic [1:0] frame_shift(input fmt_t f);
      return {1'b0, f.wide16} + {1'b0, f.stereo};
   endfunction
endpackage

// File: rtl/vag_regs.sv
module vag_regs
   import vag_pkg::*;
#(
   parameter int unsigned ADDR_W = 30,
   parameter int unsigned OFS_W  = 16,
   parameter int unsigned STEP_W = 16,
   parameter int unsigned DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [SEL_W-1:0]    wr_sel,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [ADDR_W-1:0]   base_q,
   output logic [OFS_W-1:0]    end_q,
   output logic [STEP_W-1:0]   step_q,
   output fmt_t                fmt_q,
   output logic                cur_wr,
   output logic [OFS_W-1:0]    cur_wdata
);
   if (ADDR_W > DATA_W || OFS_W > DATA_W || STEP_W > DATA_W) begin : g_bad_w
      $error("vag_regs: field wider than write data");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         end_q  <= '0;
         step_q <= '0;
         fmt_q  <= '0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_BASE: base_q <= wr_data[ADDR_W-1:0];
            SEL_END:  end_q  <= wr_data[OFS_W-1:0];
            SEL_STEP: step_q <= wr_data[STEP_W-1:0];
            SEL_FMT:  fmt_q  <= fmt_unpack(wr_data[FMT_W-1:0]);
            default: ;
         endcase
      end
   end

   assign cur_wr    = wr_en && (wr_sel == SEL_CUR);
   assign cur_wdata = wr_data[OFS_W-1:0];
endmodule

// File: rtl/vag_phase.sv
module vag_phase
   import vag_pkg::*;
#(
   parameter int unsigned OFS_W  = 16,
   parameter int unsigned FRAC_W = 12,
   parameter int unsigned STEP_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               stop,
   input  logic               tick,
   input  logic [OFS_W-1:0]   end_q,
   input  logic [STEP_W-1:0]  step_q,
   input  fmt_t               fmt_q,
   input  logic               cur_wr,
   input  logic [OFS_W-1:0]   cur_wdata,
   output logic               run_q,
   output logic [OFS_W-1:0]   cur_q,
   output logic               half_q,
   output logic               req_q,
   output logic               irq_q
);
   localparam int unsigned POS_W = OFS_W + FRAC_W + 1;
   localparam int unsigned INT_W = OFS_W + 1;

   if (STEP_W > OFS_W + FRAC_W) begin : g_bad_step
      $error("vag_phase: step wider than position");
   end

   logic [FRAC_W-1:0] frac_q, frac_n;
   logic [OFS_W-1:0]  cur_n;
   logic              run_n, half_n, req_n;
   logic [POS_W-1:0]  sum;
   logic [INT_W-1:0]  new_int, end_ext, thr;
   logic              overrun;

   assign sum     = {1'b0, cur_q, frac_q} + POS_W'(step_q);
   assign new_int = sum[POS_W-1:FRAC_W];
   assign end_ext = {1'b0, end_q};
   assign thr     = (end_ext + INT_W'(1)) >> 1;
   assign overrun = new_int > end_ext;

   always_comb begin
      run_n  = run_q;
      cur_n  = cur_q;
      frac_n = frac_q;
      half_n = half_q;
      req_n  = 1'b0;
      if (stop) begin
         run_n = 1'b0;
      end else if (start) begin
         run_n  = 1'b1;
         cur_n  = '0;
         frac_n = '0;
         half_n = 1'b0;
      end else if (tick && run_q) begin
         if (overrun && fmt_q.loop_en) begin
            cur_n  = '0;
            frac_n = sum[FRAC_W-1:0];
            half_n = 1'b0;
            req_n  = 1'b1;
         end else if (overrun) begin
            cur_n  = end_q;
            frac_n = '0;
            run_n  = 1'b0;
            half_n = end_ext >= thr;
            req_n  = end_q != cur_q;
         end else begin
            cur_n  = new_int[OFS_W-1:0];
            frac_n = sum[FRAC_W-1:0];
            half_n = new_int >= thr;
            req_n  = new_int[OFS_W-1:0] != cur_q;
         end
      end else if (cur_wr && !run_q) begin
         cur_n  = cur_wdata;
         frac_n = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         cur_q  <= '0;
         frac_q <= '0;
         half_q <= 1'b0;
         req_q  <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         run_q  <= run_n;
         cur_q  <= cur_n;
         frac_q <= frac_n;
         half_q <= half_n;
         req_q  <= req_n;
         irq_q  <= half_n != half_q;
      end
   end

   AST_WITHIN_END: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run_q && !stop && !start) |=> (cur_q <= $past(end_q))); // R5

   AST_HALF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (half_q != $past(half_q)) |-> irq_q); // R7

   AST_REQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> $past(tick)); // R8

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !start && !cur_wr) |=> $stable(cur_q)); // R11

   AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !run_q); // R3
endmodule

// File: rtl/vag_addr.sv
module vag_addr
   import vag_pkg::*;
#(
   parameter int unsigned ADDR_W = 30,
   parameter int unsigned OFS_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] base_q,
   input  logic [OFS_W-1:0]  cur_q,
   input  fmt_t              fmt_q,
   output logic [ADDR_W-1:0] addr
);
   localparam int unsigned MAX_SH = 2;
   logic [ADDR_W-1:0] byte_ofs;
   logic [1:0]        sh;

   assign sh = frame_shift(fmt_q);

   if (OFS_W + MAX_SH <= ADDR_W) begin : g_fits
      logic [ADDR_W-1:0] ofs_ext;
      assign ofs_ext  = ADDR_W'(cur_q);
      assign byte_ofs = ofs_ext << sh;
   end else begin : g_trunc
      logic [OFS_W+MAX_SH-1:0] wide_ofs;
      assign wide_ofs = {{MAX_SH{1'b0}}, cur_q} << sh;
      assign byte_ofs = wide_ofs[ADDR_W-1:0];
   end

   assign addr = base_q + byte_ofs;

   AST_FRAME_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_q.wide16 && fmt_q.stereo) |-> (addr[1:0] == base_q[1:0])); // R9
endmodule

// File: rtl/voice_addr_gen.sv
module voice_addr_gen
   import vag_pkg::*;
#(
   parameter bit          WIDE_OFS = 1'b0,
   parameter int unsigned ADDR_W   = 30,
   parameter int unsigned STEP_W   = 16,
   parameter int unsigned FRAC_W   = 12,
   parameter int unsigned DATA_W   = 32,
   localparam int unsigned OFS_W   = WIDE_OFS ? 24 : 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [31:0]       wr_data,
   input  logic              start,
   input  logic              stop,
   input  logic              tick,
   output logic              running,
   output logic [OFS_W-1:0]  cur_ofs,
   output logic              half,
   output logic              half_irq,
   output logic              req,
   output logic [29:0]       addr
);
   if (ADDR_W != 30 || DATA_W != 32) begin : g_bad_port
      $error("voice_addr_gen: port widths fixed at 30-bit address, 32-bit data");
   end
   if (FRAC_W == 0) begin : g_bad_frac
      $error("voice_addr_gen: fraction width must be nonzero");
   end

   logic [ADDR_W-1:0] base_q;
   logic [OFS_W-1:0]  end_q, cur_wdata;
   logic [STEP_W-1:0] step_q;
   fmt_t              fmt_q;
   logic              cur_wr;

   vag_regs #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .STEP_W(STEP_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .base_q(base_q), .end_q(end_q), .step_q(step_q), .fmt_q(fmt_q),
      .cur_wr(cur_wr), .cur_wdata(cur_wdata)
   );

   vag_phase #(.OFS_W(OFS_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .tick(tick),
      .end_q(end_q), .step_q(step_q), .fmt_q(fmt_q),
      .cur_wr(cur_wr), .cur_wdata(cur_wdata),
      .run_q(running), .cur_q(cur_ofs), .half_q(half), .req_q(req), .irq_q(half_irq)
   );

   vag_addr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .base_q(base_q), .cur_q(cur_ofs), .fmt_q(fmt_q), .addr(addr)
   );

   AST_OFS_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (running && cur_wr && !stop && !start && !tick) |=> $stable(cur_ofs)); // R10
endmodule

// File: tb/voice_addr_gen_test.sv
`timescale 1ns/1ps
module voice_addr_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic        start = 1'b0, stop = 1'b0, tick = 1'b0;
   logic        running, half, half_irq, req;
   logic [15:0] cur_ofs;
   logic [29:0] addr;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // bench model state
   bit       m_run, m_half, m_req, m_irq;
   longint   m_cur, m_frac, m_base, m_end, m_step, m_fmt;
   string    m_tag;

   always #4 clk = ~clk;

   voice_addr_gen uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .start(start), .stop(stop), .tick(tick), .running(running), .cur_ofs(cur_ofs),
      .half(half), .half_irq(half_irq), .req(req), .addr(addr)
   );

   function automatic longint exp_addr();
      longint sh = ((m_fmt >> 3) & 1) + ((m_fmt >> 2) & 1);
      return (m_base + (m_cur << sh)) & 64'h3FFF_FFFF;
   endfunction

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic chk_all();
      chk("R3", "running", running, m_run);
      chk(m_tag, "cur_ofs", cur_ofs, m_cur);
      chk("R7", "half", half, m_half);
      chk("R7", "half_irq", half_irq, m_irq);
      chk("R8", "req", req, m_req);
      chk("R9", "addr", addr, exp_addr());
   endtask

   task automatic model_reset();
      m_run = 0; m_half = 0; m_req = 0; m_irq = 0;
      m_cur = 0; m_frac = 0; m_base = 0; m_end = 0; m_step = 0; m_fmt = 0;
      m_tag = "R1";
   endtask

   task automatic model_step(input bit we, input int sel, input longint d,
                             input bit st, input bit sp, input bit tk);
      bit     old_half = m_half;
      longint sum, ni, thr;
      m_req = 0;
      m_tag = "R4";
      if (sp) begin
         m_run = 0;
      end else if (st) begin
         m_run = 1; m_cur = 0; m_frac = 0; m_half = 0;
      end else if (tk && m_run) begin
         sum = (m_cur << 12) + m_frac + m_step;
         ni  = sum >> 12;
         thr = (m_end + 1) >> 1;
         if (ni > m_end && (m_fmt & 1)) begin
            m_cur = 0; m_frac = sum & 12'hFFF; m_half = 0; m_req = 1; m_tag = "R5";
         end else if (ni > m_end) begin
            m_req = (m_end != m_cur); m_cur = m_end; m_frac = 0; m_run = 0;
            m_half = 1; m_tag = "R6";
         end else begin
            m_req = (ni != m_cur); m_cur = ni; m_frac = sum & 12'hFFF;
            m_half = (ni >= thr);
         end
      end else if (we && sel == 1 && !m_run) begin
         m_cur = d & 16'hFFFF; m_frac = 0; m_tag = "R2";
      end else if (!m_run && tk) begin
         m_tag = "R11";
      end
      if (we && sel == 1 && m_run && !sp && !st && !tk) m_tag = "R10";
      m_irq = (m_half != old_half);
      if (we) begin
         case (sel)
            0: m_base = d & 32'h3FFF_FFFF;
            2: m_end  = d & 16'hFFFF;
            3: m_step = d & 16'hFFFF;
            4: m_fmt  = d & 4'hF;
            default: ;
         endcase
      end
   endtask

   // one cycle: drive at negedge, model after posedge, compare at next negedge
   task automatic cyc(input bit we, input int sel, input longint d,
                      input bit st, input bit sp, input bit tk);
      wr_en = we; wr_sel = 3'(sel); wr_data = 32'(d);
      start = st; stop = sp; tick = tk;
      @(posedge clk);
      model_step(we, sel, d, st, sp, tk);
      @(negedge clk);
      wr_en = 0; start = 0; stop = 0; tick = 0;
      chk_all();
   endtask

   task automatic wr(input int sel, input longint d);
      cyc(1, sel, d, 0, 0, 0);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7321));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1", "running", running, 0);
      chk("R1", "cur_ofs", cur_ofs, 0);
      chk("R1", "half", half, 0);
      chk("R1", "addr", addr, 0);

      // R2: base keeps only 30 bits
      wr(0, 64'hC000_0100);
      chk("R2", "base top bits dropped", addr, 30'h100);

      // loop, 16-bit mono: one sample per tick (R4), wrap at end 7 (R5)
      wr(2, 7); wr(3, 16'h1000); wr(4, 4'h9);
      cyc(0, 0, 0, 1, 0, 0);
      for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 1);
      chk("R4", "one sample per tick", cur_ofs, 5);
      chk("R9", "16-bit frame address", addr, 30'h100 + 10);
      // R10: offset write while running ignored
      cyc(1, 1, 3, 0, 0, 0);
      chk("R10", "cur write while running", cur_ofs, 5);
      for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 1);
      chk("R5", "wrap to zero", cur_ofs, 0);
      chk("R7", "half cleared by wrap", half, 0);

      // R11: ticks while stopped ignored
      cyc(0, 0, 0, 0, 1, 0);
      cyc(0, 0, 0, 0, 0, 1);
      cyc(0, 0, 0, 0, 0, 1);
      chk("R11", "stopped tick", cur_ofs, 0);
      // R2: offset write while stopped loads
      wr(1, 6);
      chk("R2", "cur write while stopped", cur_ofs, 6);
      // R9: stereo 16-bit frame size 4
      wr(4, 4'hC);
      chk("R9", "stereo 16-bit address", addr, 30'h100 + 24);
      // R3: stop wins over start
      cyc(0, 0, 0, 1, 1, 0);
      chk("R3", "stop beats start", running, 0);

      // R6: non-looping, 1.5 samples per tick, end 3
      wr(4, 0); wr(2, 3); wr(3, 16'h1800);
      cyc(0, 0, 0, 1, 0, 0);
      for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 1);
      chk("R6", "halt at end", cur_ofs, 3);
      chk("R6", "stopped after end", running, 0);

      // constrained random mix
      for (int i = 0; i < 6000; i++) begin
         bit     we = ($urandom % 6) == 0;
         int     sel = $urandom % 6;
         longint d = $urandom;
         if (sel == 1 || sel == 2) d = d % 48;
         if (sel == 3) d = d % 16'h5000;
         cyc(we, sel, d, ($urandom % 50) == 0, ($urandom % 120) == 0, ($urandom % 3) != 0);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule